// File: doc/BRIEF.md
# Integer Multiply-Accumulate Unit

This block is the multiply datapath of a processor execute stage. Each request carries two 32-bit source operands, an optional accumulator (a low word alone, or a high/low pair) and a three-bit operation select. The unit returns either the low 32 bits of a product or sum, or a full 64-bit result split into high and low words. If the request asks for it, the unit also produces a negative and a zero flag.

Requests are accepted on any cycle in which `req_valid_i` and `req_ready_o` are both high. Ready rises on the first clock after reset and stays high, so back-to-back requests are allowed. Every accepted request produces exactly one result, marked by `res_valid_o`, a fixed two cycles after it was accepted. Register access, decode and condition handling are done by the surrounding pipeline.

Top module: `mac_unit`

## Requirements
- R1: While `rst_ni` is low, `req_ready_o`, `res_valid_o` and `flag_valid_o` are low. From the first rising clock edge after reset is released, `req_ready_o` is high.
- R2: A request accepted at clock edge k drives `res_valid_o` high for exactly one cycle after edge k+2. No result appears without an accepted request. Requests may arrive back to back.
- R3: Op code 3'b000 returns bits [31:0] of a*b on `res_lo_o`, and `res_hi_o` is zero.
- R4: Op code 3'b001 returns bits [31:0] of a*b + acc_lo, wrapping modulo 2^32, and `res_hi_o` is zero.
- R5: Op code 3'b100 returns the 64-bit product of a and b, both taken as unsigned. `res_hi_o` carries bits [63:32] and `res_lo_o` carries bits [31:0].
- R6: Op code 3'b101 returns the unsigned 64-bit product plus {acc_hi, acc_lo}, wrapping modulo 2^64.
- R7: Op code 3'b110 returns the 64-bit product of a and b, both taken as two's complement.
- R8: Op code 3'b111 returns the signed 64-bit product plus {acc_hi, acc_lo}, wrapping modulo 2^64.
- R9: When op bit 2 is zero, op bit 1 is ignored: 3'b010 behaves as 3'b000 and 3'b011 behaves as 3'b001.
- R10: For a request with `set_flags_i` high, `flag_valid_o` rises together with its result. `flag_n_o` equals result bit 31 for low-word forms and bit 63 for long forms. `flag_z_o` is high exactly when the returned result is zero: the low word for low-word forms, all 64 bits for long forms.
- R11: For a result whose request had `set_flags_i` low, and in any cycle with no flag update, `flag_valid_o` is low and `flag_n_o` and `flag_z_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Unit can accept a request |
| op_i | input | 3 | Operation select (see R3 to R9) |
| set_flags_i | input | 1 | Produce N and Z flags for this request |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Second operand |
| acc_hi_i | input | 32 | Accumulator high word (long accumulate forms) |
| acc_lo_i | input | 32 | Accumulator low word |
| res_valid_o | output | 1 | Result strobe |
| res_hi_o | output | 32 | Result bits [63:32], zero for low-word forms |
| res_lo_o | output | 32 | Result bits [31:0] |
| flag_valid_o | output | 1 | Flags updated with this result |
| flag_n_o | output | 1 | Negative flag, held between updates |
| flag_z_o | output | 1 | Zero flag, held between updates |

## Verification
The hardest behaviour to reach from the ports is an accumulation whose carry crosses the 32-bit or 64-bit boundary and wraps. It has to happen while results stream back to back, and while the flag outputs hold across results that did not ask for an update. The stimulus first sweeps every op code, including the two aliased codes, over operand and accumulator values drawn from 0, 1, 0x7FFF_FFFF, 0x8000_0000 and 0xFFFF_FFFF. Those values make signed and unsigned products differ and push sums through zero. A long random run then mixes idle gaps with flag requests that are set on some cycles and clear on others, so that held flags are checked next to fresh ones.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    OP_LO_MUL     = 3'b000,
    OP_LO_MAC     = 3'b001,
    OP_U_LONG     = 3'b100,
    OP_U_LONG_ACC = 3'b101,
    OP_S_LONG     = 3'b110,
    OP_S_LONG_ACC = 3'b111
  } mac_op_e;

  typedef struct packed {
    logic is_long;
    logic is_signed;
    logic do_acc;
  } mac_dec_t;

  // bit 1 only matters for long forms
  function automatic mac_dec_t mac_decode(logic [2:0] op);
    mac_dec_t d;
    d.is_long   = op[2];
    d.is_signed = op[2] & op[1];
    d.do_acc    = op[0];
    return d;
  endfunction

endpackage

// File: rtl/mac_operand_prep.sv
module mac_operand_prep
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OPR_W = DATA_W + 1,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [DATA_W-1:0] acc_hi_i,
  input  logic [DATA_W-1:0] acc_lo_i,
  output logic [OPR_W-1:0]  opa_o,
  output logic [OPR_W-1:0]  opb_o,
  output logic [RES_W-1:0]  addend_o,
  output logic              is_long_o
);

  mac_dec_t dec;
  logic     ext_a;
  logic     ext_b;

  assign dec   = mac_decode(op_i);
  assign ext_a = dec.is_signed & src_a_i[DATA_W-1];
  assign ext_b = dec.is_signed & src_b_i[DATA_W-1];

  assign opa_o     = {ext_a, src_a_i};
  assign opb_o     = {ext_b, src_b_i};
  assign is_long_o = dec.is_long;

  always_comb begin
    addend_o = '0;
    if (dec.do_acc) begin
      if (dec.is_long) addend_o = {acc_hi_i, acc_lo_i};
      else             addend_o = {{DATA_W{1'b0}}, acc_lo_i};
    end
  end

endmodule

// File: rtl/mac_product_sum.sv
module mac_product_sum #(
  parameter int DATA_W = 32,
  localparam int OPR_W = DATA_W + 1,
  localparam int RES_W = 2 * DATA_W,
  localparam int PRD_W = 2 * OPR_W
) (
  input  logic [OPR_W-1:0] opa_i,
  input  logic [OPR_W-1:0] opb_i,
  input  logic [RES_W-1:0] addend_i,
  output logic [RES_W-1:0] sum_o
);

  logic signed [PRD_W-1:0] opa_w;
  logic signed [PRD_W-1:0] opb_w;
  logic signed [PRD_W-1:0] prod;

  assign opa_w = {{OPR_W{opa_i[OPR_W-1]}}, opa_i};
  assign opb_w = {{OPR_W{opb_i[OPR_W-1]}}, opb_i};
  assign prod  = opa_w * opb_w;
  assign sum_o = prod[RES_W-1:0] + addend_i;

endmodule

// File: rtl/mac_result_pack.sv
module mac_result_pack #(
  parameter int DATA_W = 32,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic [RES_W-1:0]  sum_i,
  input  logic              is_long_i,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic              neg_o,
  output logic              zero_o
);

  logic lo_zero;
  logic hi_zero;

  assign lo_o    = sum_i[DATA_W-1:0];
  assign hi_o    = is_long_i ? sum_i[RES_W-1:DATA_W] : '0;
  assign lo_zero = (lo_o == '0);
  assign hi_zero = (hi_o == '0);
  assign neg_o   = is_long_i ? sum_i[RES_W-1] : sum_i[DATA_W-1];
  assign zero_o  = lo_zero & hi_zero;

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OPR_W = DATA_W + 1,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        op_i,
  input  logic              set_flags_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [DATA_W-1:0] acc_hi_i,
  input  logic [DATA_W-1:0] acc_lo_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_hi_o,
  output logic [DATA_W-1:0] res_lo_o,
  output logic              flag_valid_o,
  output logic              flag_n_o,
  output logic              flag_z_o
);

  logic             ready_q;
  logic             accept;

  logic [OPR_W-1:0] opa_d, opb_d;
  logic [RES_W-1:0] addend_d;
  logic             long_d;

  logic             s1_valid_q, s1_flags_q, s1_long_q;
  logic [OPR_W-1:0] s1_opa_q, s1_opb_q;
  logic [RES_W-1:0] s1_addend_q;

  logic [RES_W-1:0]  sum;
  logic [DATA_W-1:0] hi_d, lo_d;
  logic              neg_d, zero_d;

  assign req_ready_o = ready_q;
  assign accept      = req_valid_i & ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end

  mac_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .op_i      (op_i),
    .src_a_i   (src_a_i),
    .src_b_i   (src_b_i),
    .acc_hi_i  (acc_hi_i),
    .acc_lo_i  (acc_lo_i),
    .opa_o     (opa_d),
    .opb_o     (opb_d),
    .addend_o  (addend_d),
    .is_long_o (long_d)
  );

  // stage 1: capture prepared operands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q  <= 1'b0;
      s1_flags_q  <= 1'b0;
      s1_long_q   <= 1'b0;
      s1_opa_q    <= '0;
      s1_opb_q    <= '0;
      s1_addend_q <= '0;
    end else begin
      s1_valid_q <= accept;
      if (accept) begin
        s1_flags_q  <= set_flags_i;
        s1_long_q   <= long_d;
        s1_opa_q    <= opa_d;
        s1_opb_q    <= opb_d;
        s1_addend_q <= addend_d;
      end
    end
  end

  mac_product_sum #(.DATA_W(DATA_W)) u_mul (
    .opa_i    (s1_opa_q),
    .opb_i    (s1_opb_q),
    .addend_i (s1_addend_q),
    .sum_o    (sum)
  );

  mac_result_pack #(.DATA_W(DATA_W)) u_pack (
    .sum_i     (sum),
    .is_long_i (s1_long_q),
    .hi_o      (hi_d),
    .lo_o      (lo_d),
    .neg_o     (neg_d),
    .zero_o    (zero_d)
  );

  // stage 2: result and flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_hi_o     <= '0;
      res_lo_o     <= '0;
      flag_valid_o <= 1'b0;
      flag_n_o     <= 1'b0;
      flag_z_o     <= 1'b0;
    end else begin
      res_valid_o  <= s1_valid_q;
      flag_valid_o <= s1_valid_q & s1_flags_q;
      if (s1_valid_q) begin
        res_hi_o <= hi_d;
        res_lo_o <= lo_d;
      end
      if (s1_valid_q && s1_flags_q) begin
        flag_n_o <= neg_d;
        flag_z_o <= zero_d;
      end
    end
  end

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [2:0]        op_i,
  input logic              set_flags_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic [DATA_W-1:0] src_b_i,
  input logic              res_valid_o,
  input logic [DATA_W-1:0] res_hi_o,
  input logic [DATA_W-1:0] res_lo_o,
  input logic              flag_valid_o,
  input logic              flag_n_o,
  input logic              flag_z_o
);

  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  function automatic logic [DATA_W-1:0] lo_prod(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    logic [2*DATA_W-1:0] p;
    p = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
    return p[DATA_W-1:0];
  endfunction

  p_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1) |-> req_ready_o);

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (res_valid_o == $past(req_valid_i && req_ready_o, 2)));

  p_hi_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && res_valid_o && !$past(op_i[2], 2)) |-> (res_hi_o == '0));

  p_lo_mul_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && res_valid_o && $past(op_i, 2) == 3'b000)
      |-> (res_lo_o == lo_prod($past(src_a_i, 2), $past(src_b_i, 2))));

  p_flag_with_res_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_valid_o |-> res_valid_o);

  p_flag_n_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && flag_valid_o)
      |-> (flag_n_o == ($past(op_i[2], 2) ? res_hi_o[DATA_W-1] : res_lo_o[DATA_W-1])));

  p_flag_z_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_valid_o |-> (flag_z_o == (res_hi_o == '0 && res_lo_o == '0)));

  p_flag_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && res_valid_o) |-> (flag_valid_o == $past(set_flags_i, 2)));

  p_flag_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && !flag_valid_o) |-> ($stable(flag_n_o) && $stable(flag_z_o)));

endmodule

bind mac_unit mac_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .op_i         (op_i),
  .set_flags_i  (set_flags_i),
  .src_a_i      (src_a_i),
  .src_b_i      (src_b_i),
  .res_valid_o  (res_valid_o),
  .res_hi_o     (res_hi_o),
  .res_lo_o     (res_lo_o),
  .flag_valid_o (flag_valid_o),
  .flag_n_o     (flag_n_o),
  .flag_z_o     (flag_z_o)
);

// File: tb/mac_unit_tb.sv
module mac_unit_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [2:0]  op_i = 3'b000;
  logic        set_flags_i = 1'b0;
  logic [31:0] src_a_i = '0, src_b_i = '0, acc_hi_i = '0, acc_lo_i = '0;
  logic        res_valid_o;
  logic [31:0] res_hi_o, res_lo_o;
  logic        flag_valid_o, flag_n_o, flag_z_o;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    bit          v;
    bit          fl;
    bit          lng;
    logic [2:0]  op;
    logic [63:0] r;
  } exp_t;

  exp_t e1, e2;
  bit   held_n, held_z;

  always #5 clk_i = ~clk_i;

  mac_unit u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .op_i, .set_flags_i,
    .src_a_i, .src_b_i, .acc_hi_i, .acc_lo_i, .res_valid_o, .res_hi_o,
    .res_lo_o, .flag_valid_o, .flag_n_o, .flag_z_o
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'b000: return "R3";
      3'b001: return "R4";
      3'b010, 3'b011: return "R9";
      3'b100: return "R5";
      3'b101: return "R6";
      3'b110: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [63:0] ref_calc(logic [2:0] op, logic [31:0] a, logic [31:0] b,
                                          logic [31:0] hi, logic [31:0] lo);
    logic [63:0] p, r;
    longint sa, sb;
    if (op[2] && op[1]) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      p  = 64'(sa * sb);
    end else begin
      p = {32'h0, a} * {32'h0, b};
    end
    r = p;
    if (op[0]) r = r + (op[2] ? {hi, lo} : {32'h0, lo});
    if (!op[2]) r = {32'h0, r[31:0]};
    return r;
  endfunction

  // one cycle: check outputs for the request two steps back, then drive a new one
  task automatic step(bit v, logic [2:0] op, bit fl, logic [31:0] a, logic [31:0] b,
                      logic [31:0] hi, logic [31:0] lo);
    bit en, ez;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1", 64'(req_ready_o), 64'd1);
    chk(res_valid_o == e2.v, "R2", 64'(res_valid_o), 64'(e2.v));
    if (e2.v) begin
      chk({res_hi_o, res_lo_o} == e2.r, op_tag(e2.op), {res_hi_o, res_lo_o}, e2.r);
      if (e2.fl) begin
        en = e2.lng ? e2.r[63] : e2.r[31];
        ez = (e2.r == 64'h0);
        held_n = en;
        held_z = ez;
      end
    end
    chk(flag_valid_o == (e2.v && e2.fl), e2.fl ? "R10" : "R11",
        64'(flag_valid_o), 64'(e2.v && e2.fl));
    chk({flag_n_o, flag_z_o} == {held_n, held_z}, (e2.v && e2.fl) ? "R10" : "R11",
        64'({flag_n_o, flag_z_o}), 64'({held_n, held_z}));
    e2 = e1;
    e1.v   = v;
    e1.fl  = fl;
    e1.lng = op[2];
    e1.op  = op;
    e1.r   = ref_calc(op, a, b, hi, lo);
    req_valid_i = v;
    op_i        = op;
    set_flags_i = fl;
    src_a_i     = a;
    src_b_i     = b;
    acc_hi_i    = hi;
    acc_lo_i    = lo;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] vals [5];
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h7FFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF;
    e1 = '{default: 0};
    e2 = '{default: 0};
    held_n = 0;
    held_z = 0;

    // R1: reset state
    repeat (3) begin
      @(negedge clk_i);
      chk(!req_ready_o && !res_valid_o && !flag_valid_o, "R1",
          64'({req_ready_o, res_valid_o, flag_valid_o}), 64'd0);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // boundary sweep over every op code, back to back
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          step(1'b1, 3'(op), ((i + j + op) % 3) != 0, vals[i], vals[j],
               vals[(i * j + op) % 5], vals[(i + 2 * j + op) % 5]);

    // wrap to zero: -1 * 1 + 1
    step(1'b1, 3'b111, 1'b1, 32'hFFFF_FFFF, 32'h1, 32'h0, 32'h1);
    step(1'b1, 3'b001, 1'b1, 32'hFFFF_FFFF, 32'h1, 32'h0, 32'h1);
    step(1'b1, 3'b101, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF);
    step(1'b0, 3'b000, 1'b0, '0, '0, '0, '0);

    // random traffic with gaps
    for (int k = 0; k < 3000; k++)
      step(($urandom % 4) != 0, 3'($urandom), $urandom % 2,
           (k % 7 == 0) ? vals[$urandom % 5] : $urandom,
           $urandom, $urandom, $urandom);

    repeat (3) step(1'b0, 3'b000, 1'b0, '0, '0, '0, '0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule